// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master for a CPU register bus. Both directions are buffered once ahead of the shift register. The CPU can place the next outgoing byte in a holding register while the current byte is still shifting. When that byte's last SCK edge arrives, the held byte moves into the shifter, so a run of queued bytes goes out with no idle time between them. Each completed incoming byte is copied into a receive register. It stays there until the CPU collects it with a fixed access sequence.

The bus has two addresses. Address 0 is the data register: a write queues a transmit byte and a read returns the last received byte. Address 1 is the status register. Status bits: bit 0 transmit-empty, bit 1 receive-full, bit 2 overflow, bit 3 write-error, bit 4 busy, and the other bits read 0. Read data is registered and is valid in the cycle after the read strobe. The SCK polarity, SCK phase and divider select are static configuration inputs. They are changed only while the block is idle.

Top module: `spi_dbuf_master`

## Requirements
- R1: A data-register write made while transmit-empty is 1 stores the byte in the holding register, and transmit-empty reads 0 in the next cycle.
- R2: A held byte moves into the shifter when the shifter is idle, or on the last SCK edge of the current byte. Transmit-empty returns to 1 in that same cycle.
- R3: Queued bytes go out back-to-back: every SCK edge in a run, across byte boundaries, is exactly one half SCK period after the previous edge.
- R4: A data-register write made while transmit-empty is 0 has no effect on the data sent. It sets the sticky write-error status bit 3, which a status read clears.
- R5: When a byte completes, the 8 sampled MISO bits go to the receive register and receive-full (status bit 1) is set.
- R6: Receive-full clears only when a status read made while it is set is followed by a data read. A data read with no such status read before it returns the data and leaves the flag set.
- R7: If a byte completes while receive-full is still set, overflow (status bit 2) is set and the receive register keeps the older byte. A status read clears overflow.
- R8: Data is shifted most significant bit first, 8 bits per byte, on both MOSI and MISO.
- R9: With phase 0, the first bit is on MOSI before the first SCK edge, bits are sampled on odd edges and driven on even edges. With phase 1, bits are driven on odd edges and sampled on even edges. SCK rests at the polarity level whenever no byte is in progress.
- R10: The divider select values 0, 1, 2 and 3 give an SCK period of 2, 8, 16 and 32 system clocks.
- R11: After reset, transmit-empty is 1, receive-full, overflow, write-error and busy are 0, and SCK is at the polarity level.
- R12: Busy is 0 until the first SCK edge of a run. It is 1 from that edge until the last edge of the final queued byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | SCK phase select |
| cfg_div | input | 2 | SCK divider select (2, 8, 16, 32) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tx_empty | output | 1 | Holding register can accept a byte |
| rx_full | output | 1 | Received byte is waiting |
| busy | output | 1 | Transfer run in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check these rules on every cycle:
- transmit-empty rises only when the shifter loads a byte;
- receive-full rises only when a byte completes, and falls only after a data read;
- a write refused while the holding register is full leaves the register unchanged;
- an overflowing byte leaves the receive register unchanged;
- MOSI shows the MSB right after a load;
- SCK holds between divider ticks.

Other behaviour only the bench can show. It sweeps all four clock modes against all four divider settings, with a serial peer model on the pins. That covers the gapless edge spacing across a three-byte run, the byte values seen on both data lines, and the sticky status bits. It also covers the status-then-data clear sequence and the lone data read that must not clear.

// File: rtl/spi_dbuf_pkg.sv
`timescale 1ns/1ps
package spi_dbuf_pkg;
  localparam int BYTE_W = 8;
  // status register bit positions
  localparam int ST_TXE  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_OVF  = 2;
  localparam int ST_WERR = 3;
  localparam int ST_BUSY = 4;
  // register addresses
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // half period in clocks: 1, 4, 8, 16
  always_comb begin
    lim  = (div_sel == 2'd0) ? '0 : CNT_W'((2 << div_sel) - 1);
    tick = run && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
`timescale 1ns/1ps
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         tick,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_byte,
  input  logic         miso,
  output logic         run,
  output logic         load_ack,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         sck,
  output logic         mosi,
  output logic         busy
);
  localparam int EDGES = 2 * W;
  localparam int EC_W  = $clog2(EDGES);

  logic [EC_W-1:0] ecnt;
  logic [W-1:0]    sr;
  logic [W-1:0]    rsr;
  logic            lead, last_edge, do_sample, do_shift;

  always_comb begin
    lead      = ~ecnt[0];
    last_edge = (ecnt == EC_W'(EDGES - 1));
    do_sample = cpha ? !lead : lead;
    do_shift  = cpha ? (lead && (ecnt != '0)) : (!lead && !last_edge);
    load_ack  = tx_valid && (!run || (tick && last_edge));
  end

  assign mosi = sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      busy      <= 1'b0;
      sck       <= cpol;
      ecnt      <= '0;
      sr        <= '0;
      rsr       <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!run) sck <= cpol;
      if (tick) begin
        sck  <= ~sck;
        ecnt <= ecnt + 1'b1;
        busy <= 1'b1;
        if (do_sample) rsr <= {rsr[W-2:0], miso};
        if (do_shift)  sr  <= {sr[W-2:0], 1'b0};
        if (last_edge) begin
          byte_done <= 1'b1;
          rx_byte   <= cpha ? {rsr[W-2:0], miso} : rsr;
          ecnt      <= '0;
          if (!tx_valid) begin
            run  <= 1'b0;
            busy <= 1'b0;
          end
        end
      end
      if (load_ack) begin
        sr  <= tx_byte;
        run <= 1'b1;
      end
    end
  end

  // R12
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> sck == cpol);
  // R8
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    load_ack |=> mosi == $past(tx_byte[W-1]));
  // R10
  sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run && !tick |=> $stable(sck));
endmodule

// File: rtl/spi_cpu_regs.sv
`timescale 1ns/1ps
module spi_cpu_regs
  import spi_dbuf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic         bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic         load_ack,
  input  logic         byte_done,
  input  logic         busy,
  input  logic [W-1:0] rx_byte,
  output logic         tx_valid,
  output logic [W-1:0] tx_byte,
  output logic         tx_empty,
  output logic         rx_full,
  output logic [W-1:0] bus_rdata
);
  logic         ovf, werr, arm;
  logic [W-1:0] rx_data;
  logic         wr_data, rd_data, rd_stat, clr;
  logic [W-1:0] status;

  always_comb begin
    wr_data = bus_wr && (bus_addr == ADDR_DATA);
    rd_data = bus_rd && (bus_addr == ADDR_DATA);
    rd_stat = bus_rd && (bus_addr == ADDR_STAT);
    clr     = rd_data && arm;
    status          = '0;
    status[ST_TXE]  = tx_empty;
    status[ST_RXF]  = rx_full;
    status[ST_OVF]  = ovf;
    status[ST_WERR] = werr;
    status[ST_BUSY] = busy;
  end

  assign tx_valid = !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_empty  <= 1'b1;
      rx_full   <= 1'b0;
      ovf       <= 1'b0;
      werr      <= 1'b0;
      arm       <= 1'b0;
      tx_byte   <= '0;
      rx_data   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_data) begin
        if (tx_empty) begin
          tx_byte  <= bus_wdata;
          tx_empty <= 1'b0;
        end else begin
          werr <= 1'b1;
        end
      end
      if (load_ack) tx_empty <= 1'b1;
      if (rd_stat) begin
        bus_rdata <= status;
        werr      <= 1'b0;
        ovf       <= 1'b0;
        if (rx_full) arm <= 1'b1;
      end
      if (rd_data) begin
        bus_rdata <= rx_data;
        if (arm) begin
          rx_full <= 1'b0;
          arm     <= 1'b0;
        end
      end
      if (byte_done) begin
        if (!rx_full || clr) begin
          rx_data <= rx_byte;
          rx_full <= 1'b1;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    wr_data && tx_empty |=> !tx_empty && tx_byte == $past(bus_wdata));
  // R4
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_data && !tx_empty |=> $stable(tx_byte));
  // R2
  txe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> $past(load_ack));
  // R5
  rxf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(byte_done));
  // R6
  rxf_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |-> $past(rd_data));
  // R7
  ovf_keep_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done && rx_full && !clr |=> ovf && $stable(rx_data));
endmodule

// File: rtl/spi_dbuf_master.sv
`timescale 1ns/1ps
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W    = BYTE_W,
  parameter int DIV_CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [1:0]        cfg_div,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic              run, tick, load_ack, byte_done, tx_valid;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  spi_clk_div #(.CNT_W(DIV_CNT_W)) div_i (
    .clk(clk), .rst(rst), .run(run), .div_sel(cfg_div), .tick(tick)
  );

  spi_shifter #(.W(DATA_W)) shf_i (
    .clk(clk), .rst(rst), .cpol(cfg_cpol), .cpha(cfg_cpha), .tick(tick),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .miso(miso), .run(run),
    .load_ack(load_ack), .byte_done(byte_done), .rx_byte(rx_byte),
    .sck(sck), .mosi(mosi), .busy(busy)
  );

  spi_cpu_regs #(.W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .load_ack(load_ack),
    .byte_done(byte_done), .busy(busy), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_empty(tx_empty),
    .rx_full(rx_full), .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/spi_dbuf_master_tb_top.sv
`timescale 1ns/1ps
module spi_dbuf_master_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_cpol = 1'b1, cfg_cpha = 1'b0;
  logic [1:0] cfg_div = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_empty, rx_full, busy, sck, mosi, miso;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_dbuf_master dut_i (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_div(cfg_div), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  // serial peer model
  logic       mon_clr = 1'b1;
  logic       sck_prev = 1'b0, mosi_last = 1'b0;
  int         ec = 0, sl_idx = 0, ngot = 0, nedges = 0;
  int         first_cyc = 0, last_cyc = 0, cyc = 0, busy_bad = 0;
  logic [7:0] cap = 8'h00;
  logic [7:0] got [4];
  logic [7:0] sl_tx [4];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      ec = 0; sl_idx = 0; ngot = 0; nedges = 0; busy_bad = 0; cap = 8'h00;
    end else if (sck !== sck_prev) begin
      nedges = nedges + 1;
      if (nedges == 1) first_cyc = cyc;
      last_cyc = cyc;
      if (!busy && ec != 15) busy_bad = busy_bad + 1;
      ec = ec + 1;
      if (cfg_cpha ? (ec % 2 == 0) : (ec % 2 == 1)) cap = {cap[6:0], mosi_last};
      if (ec == 16) begin
        if (ngot < 4) got[ngot] = cap;
        ngot = ngot + 1;
        ec = 0;
        sl_idx = sl_idx + 1;
      end
    end
    sck_prev  = sck;
    mosi_last = mosi;
  end

  always_comb begin
    int bi;
    if (cfg_cpha) bi = (ec == 0) ? 7 : 7 - (ec - 1) / 2;
    else          bi = 7 - ec / 2;
    miso = sl_tx[sl_idx[1:0]][bi[2:0]];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_txe();
    int t = 0;
    do begin @(negedge clk); t++; end while (!tx_empty && t < 5000);
  endtask

  task automatic wait_idle();
    int t = 0;
    do begin @(negedge clk); t++; end while (busy && t < 5000);
  endtask

  task automatic run_cfg(input logic p, input logic h, input logic [1:0] dv);
    logic [7:0] m [3];
    logic [7:0] d;
    int half, base;
    base = int'({p, h, dv});
    half = (dv == 2'd0) ? 1 : (2 << dv);
    for (int k = 0; k < 3; k++) begin
      m[k]     = 8'(8'hC5 + base * 13 + k * 77);
      sl_tx[k] = 8'(8'h3C ^ (base * 37 + k * 91));
    end
    sl_tx[3] = 8'h00;
    @(negedge clk);
    mon_clr = 1'b1; cfg_cpol = p; cfg_cpha = h; cfg_div = dv;
    repeat (4) @(negedge clk);
    chk(sck == p, "R9 sck idle level", int'(sck), int'(p));
    mon_clr = 1'b0;
    bus_write(m[0]);
    chk(!tx_empty, "R1 tx_empty low after write", int'(tx_empty), 0);
    chk(!busy, "R12 busy low before first edge", int'(busy), 0);
    @(negedge clk);
    chk(tx_empty, "R2 tx_empty back after load", int'(tx_empty), 1);
    bus_write(m[1]);
    bus_write(8'hFF);
    bus_read(1'b1, d);
    chk(d[3] && !d[0], "R4 write error set", int'(d), 8'h08);
    bus_read(1'b1, d);
    chk(!d[3], "R4 write error cleared by status read", int'(d[3]), 0);
    wait_txe();
    bus_write(m[2]);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(ngot == 3, "R4 refused byte not sent", ngot, 3);
    for (int k = 0; k < 3; k++)
      chk(got[k] == m[k], "R8 R9 mosi byte", int'(got[k]), int'(m[k]));
    chk(last_cyc - first_cyc == 47 * half, "R3 R10 edge spacing",
        last_cyc - first_cyc, 47 * half);
    chk(busy_bad == 0, "R12 busy during run", busy_bad, 0);
    chk(sck == p, "R9 sck back at idle level", int'(sck), int'(p));
    bus_read(1'b1, d);
    chk(d == 8'h07, "R5 R7 status after overrun", int'(d), 8'h07);
    bus_read(1'b0, d);
    chk(d == sl_tx[0], "R7 older byte kept R5", int'(d), int'(sl_tx[0]));
    bus_read(1'b1, d);
    chk(d == 8'h01, "R6 flags cleared", int'(d), 8'h01);
  endtask

  initial begin
    logic [7:0] d;
    int t;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sck == 1'b1, "R11 sck at polarity", int'(sck), 1);
    chk(tx_empty, "R11 tx_empty", int'(tx_empty), 1);
    chk(!rx_full, "R11 rx_full", int'(rx_full), 0);
    chk(!busy, "R11 busy", int'(busy), 0);
    bus_read(1'b1, d);
    chk(d == 8'h01, "R11 status", int'(d), 8'h01);

    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int dv = 0; dv < 4; dv++)
          run_cfg(p[0], h[0], dv[1:0]);

    // lone data read must not clear receive-full
    @(negedge clk);
    mon_clr = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 2'd1;
    sl_tx[0] = 8'h5A;
    repeat (4) @(negedge clk);
    mon_clr = 1'b0;
    bus_write(8'h81);
    t = 0;
    do begin @(negedge clk); t++; end while (!rx_full && t < 5000);
    bus_read(1'b0, d);
    chk(d == 8'h5A, "R5 received byte", int'(d), 8'h5A);
    chk(rx_full, "R6 lone data read keeps flag", int'(rx_full), 1);
    bus_read(1'b1, d);
    chk(d[1], "R6 status shows rx_full", int'(d[1]), 1);
    bus_read(1'b0, d);
    chk(!rx_full, "R6 status then data clears", int'(rx_full), 0);
    chk(got[0] == 8'h81, "R8 single byte on mosi", int'(got[0]), 8'h81);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule